// File: doc/BRIEF.md
# Sixteen-Way Cascaded Priority Encoder

This block takes sixteen active-low request lines and reports which asserted request has the highest priority. It returns that request's number as a 4-bit active-high code and raises a valid flag whenever any request is asserted. Line 15 has the highest priority and line 0 the lowest. The block is purely combinational.

Inside, two identical eight-line encoder slices sit in a chain. Each slice has an active-low enable. It drives an active-low 3-bit code and an active-low group-select that says "this slice found a request". It also drives an active-low enable-out that says "I was enabled and saw nothing". The upper slice watches lines 15..8 and is always enabled. Its enable-out feeds the enable of the lower slice, which watches lines 7..0. The lower slice therefore speaks only when the upper group is silent.

The interface is plain control signalling. There is no handshake, because there is no register and no flow control on either side.

Top module: `pe_cascade16`

## Requirements
- R1: A request is asserted by driving its bit of `req_n` to 0; bit i of `req_n` belongs to request number i.
- R2: When at least one request is asserted, `code` equals the number of the highest-numbered asserted request, as an unsigned binary value.
- R3: `valid` is 1 exactly when at least one bit of `req_n` is 0.
- R4: With all sixteen bits of `req_n` at 1, `code` is 4'b0000 and `valid` is 0.
- R5: If any request in 15..8 is asserted, `code[3]` is 1 and the levels on `req_n[7:0]` have no effect on any output.
- R6: If requests 15..8 are all idle, `code[3]` is 0 and `code[2:0]` gives the highest asserted request among 7..0.
- R7: Slice behaviour: a disabled slice holds its code, group-select and enable-out at 1. An enabled slice drives exactly one of the two low: group-select when it sees a request, enable-out when it sees none.
- R8: Within a slice, its local input 7 outranks 6, and so on down to input 0, so only the topmost asserted local input is encoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_n | input | 16 | Active-low request lines, bit 15 highest priority |
| code | output | 4 | Active-high number of the winning request (0 when idle) |
| valid | output | 1 | Active-high flag, 1 when any request is asserted |

## Verification
The embedded checks assume only that `req_n` holds settled two-state values whenever outputs are examined. They make no assumption about how many requests are asserted together, so any pattern is legal. The stimulus changes `req_n` only on rising clock edges and samples on falling edges, so the combinational outputs are read after they have settled. The sweep walks every one of the 65536 request patterns. Directed vectors pin down the idle case, single requests, and the case where a masked lower group is toggled under an active upper request.

// File: rtl/pe_pkg.sv
package pe_pkg;
  // Default geometry of one encoder slice
  localparam int unsigned SLICE_LINES = 8;
  localparam int unsigned SLICE_CODE_W = $clog2(SLICE_LINES);
  // Number of slices in the cascade
  localparam int unsigned CHAIN_LEN = 2;
endpackage

// File: rtl/pe_lead_find.sv
// Finds the highest set bit of an active-high vector.
module pe_lead_find #(
  parameter int unsigned LINES = 8,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] hot,
  output logic [IDX_W-1:0] top_idx,
  output logic             any_hot
);
  always_comb begin
    top_idx = '0;
    any_hot = |hot;
    // Later (higher) indices overwrite earlier ones
    for (int i = 0; i < LINES; i++) begin
      if (hot[i]) top_idx = i[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/pe_slice.sv
// One active-low priority encoder slice with enable chaining.
module pe_slice #(
  parameter int unsigned LINES = pe_pkg::SLICE_LINES,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] lreq_n,
  input  logic             ena_n,
  output logic [IDX_W-1:0] idx_n,
  output logic             grp_n,
  output logic             nxt_n
);
  logic [IDX_W-1:0] top_idx;
  logic             any_hot;
  logic             enabled;

  pe_lead_find #(.LINES(LINES)) finder_i (
    .hot     (~lreq_n),
    .top_idx (top_idx),
    .any_hot (any_hot)
  );

  assign enabled = ~ena_n;
  assign idx_n   = (enabled && any_hot) ? ~top_idx : '1;
  assign grp_n   = ~(enabled & any_hot);
  assign nxt_n   = ~(enabled & ~any_hot);

  // Checks on slice behaviour
  always_comb begin
    if (ena_n) begin
      a_r7_disabled_quiet: assert (grp_n && nxt_n && (&idx_n));
    end else begin
      a_r7_one_of_two_low: assert (grp_n != nxt_n);
    end
    if (!grp_n) begin
      // Encoded line must be asserted and nothing above it
      a_r8_winner_asserted: assert (lreq_n[~idx_n] == 1'b0);
      a_r8_nothing_above: assert (((~lreq_n) >> (~idx_n)) == {{(LINES-1){1'b0}}, 1'b1});
    end
  end
endmodule

// File: rtl/pe_cascade16.sv
// Sixteen-line priority encoder from two chained slices.
module pe_cascade16 (
  input  logic [15:0] req_n,
  output logic [3:0]  code,
  output logic        valid
);
  localparam int unsigned W   = pe_pkg::SLICE_LINES;
  localparam int unsigned CW  = pe_pkg::SLICE_CODE_W;
  localparam int unsigned NS  = pe_pkg::CHAIN_LEN;
  localparam int unsigned TOT = W * NS;

  logic [NS:0]   en_chain;
  logic [CW-1:0] sl_idx_n [NS];
  logic [NS-1:0] sl_grp_n;
  logic [CW-1:0] idx_and;

  // The first slice (upper lines) is always enabled
  assign en_chain[0] = 1'b0;

  for (genvar s = 0; s < NS; s++) begin : g_slice
    pe_slice #(.LINES(W)) slice_i (
      .lreq_n (req_n[(NS-s)*W-1 -: W]),
      .ena_n  (en_chain[s]),
      .idx_n  (sl_idx_n[s]),
      .grp_n  (sl_grp_n[s]),
      .nxt_n  (en_chain[s+1])
    );
  end

  // Disabled slices output all ones, so AND merges the active code
  always_comb begin
    idx_and = '1;
    for (int s = 0; s < NS; s++) idx_and = idx_and & sl_idx_n[s];
  end

  assign code  = {~sl_grp_n[0], ~idx_and};
  assign valid = ~&sl_grp_n;

  // Top-level checks
  always_comb begin
    a_r3_valid_means_request: assert (valid == (req_n != {TOT{1'b1}}));
    a_r7_chain_end_idle: assert (en_chain[NS] == valid);
    if (valid) begin
      a_r2_code_is_asserted: assert (req_n[code] == 1'b0);
      a_r2_no_higher_request: assert (((~req_n) >> code) == 16'd1);
    end else begin
      a_r4_idle_code_zero: assert (code == 4'd0);
    end
  end
endmodule

// File: tb/pe_cascade16_tb_top.sv
module pe_cascade16_tb_top;
  logic        clk = 1'b0;
  logic [15:0] req_n = 16'hFFFF;
  logic [3:0]  code;
  logic        valid;
  int          n_vec = 0;
  int          n_bad = 0;

  always #2 clk = ~clk; // 250 MHz

  pe_cascade16 dut_i (
    .req_n (req_n),
    .code  (code),
    .valid (valid)
  );

  // Compare one sample against expected values
  task automatic check(input logic [3:0] exp_code, input logic exp_valid, input string tag);
    n_vec++;
    if (code !== exp_code || valid !== exp_valid) begin
      n_bad++;
      $display("FAIL %s req_n=%h code=%0d valid=%0b expected code=%0d valid=%0b",
               tag, req_n, code, valid, exp_code, exp_valid);
    end
  endtask

  // Drive a pattern on the rising edge, sample on the falling edge
  task automatic apply(input logic [15:0] pat_n);
    @(posedge clk);
    req_n = pat_n;
    @(negedge clk);
  endtask

  initial begin
    // Idle state (R4)
    apply(16'hFFFF);
    check(4'd0, 1'b0, "R4 idle");

    // Single requests, active-low polarity (R1)
    for (int i = 0; i < 16; i++) begin
      apply(~(16'd1 << i));
      check(i[3:0], 1'b1, "R1 single request");
    end

    // Upper request masks every lower pattern (R5)
    for (int lo = 0; lo < 256; lo += 37) begin
      apply({8'b1110_1111, lo[7:0]});
      check(4'd12, 1'b1, "R5 lower masked");
    end

    // Slice-local ordering: lines 7 and 0 together in lower slice (R8, R7)
    apply(16'hFF7E);
    check(4'd7, 1'b1, "R8/R7 local top wins");

    // Exhaustive sweep
    for (int p = 0; p < 65536; p++) begin
      logic [15:0] act;
      logic [3:0]  exp_c;
      act = p[15:0];
      exp_c = 4'd0;
      for (int b = 0; b < 16; b++) if (act[b]) exp_c = b[3:0];
      apply(~act);
      if (act == 16'd0)
        check(4'd0, 1'b0, "R4/R3 sweep idle");
      else if (act[15:8] != 8'd0)
        check(exp_c, 1'b1, "R5/R2/R3 sweep upper");
      else
        check(exp_c, 1'b1, "R6/R7/R2 sweep lower");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule